// File: doc/BRIEF.md
# SMBus Register-Pointer Target

This block is the serial front end of a small port-expander style register bank. It watches the two SMBus/I2C lines (SCL and SDA), which run at 10 to 100 kHz, from a much faster system clock. It finds start, repeated start and stop conditions. It answers a 7-bit address made of a fixed upper nibble and three strap pins. It acknowledges bytes by pulling SDA low.

The first byte after the address of a write transaction is a command byte. The command byte is kept as a register pointer, and the pointer survives between transactions. Bytes that follow the command are handed to the register bank with a one-cycle write strobe. A read, whether a Read Byte after a repeated start or a bare Receive Byte, fetches the register that the pointer selects. Every byte sent out fetches with its own one-cycle read strobe, so a live input port is sampled again for each byte.

The register bank sits outside this block. It decodes `cmd_ptr_o` and returns `rd_data_i` in the same cycle that `rd_pulse_o` is high.

Top module: `smb_cmdptr_target`

## Requirements
- R1: The target responds only to an address byte whose upper seven bits equal 0011 followed by `addr_sel_i[2:0]`, with bit 0 as R/W (1 = read). On a match it holds SDA low through the ninth clock. On a mismatch it never drives SDA before the next start.
- R2: A command byte received after address+W is loaded into `cmd_ptr_o` when its acknowledge clock ends. The pointer changes at no other time except reset.
- R3: Each data byte that follows the command in a write produces exactly one single-cycle `wr_pulse_o`, with the byte on `wr_data_o`, after its acknowledge clock. The write goes to the register selected by `cmd_ptr_o`.
- R4: A Read Byte (address+W, command, repeated start, address+R) shifts out the register selected by the new command, MSB first.
- R5: A Receive Byte (address+R with no command) returns the register selected by the last stored pointer. Repeated Receive Bytes keep returning that register.
- R6: Each byte sent to the controller is fetched with its own `rd_pulse_o`, so its value is sampled again. Sending continues while the controller ACKs and ends on a NACK. `rd_pulse_o` and `wr_pulse_o` are never high together.
- R7: A stop at any point returns the target to idle and releases SDA. A partly received data byte is discarded and causes no write. A stop right after the command byte leaves the pointer updated and writes nothing.
- R8: Synchronous reset `rst` releases SDA, returns the target to idle and sets the pointer to 0, which selects the input port.
- R9: A start that arrives in the middle of a transfer restarts address reception.
- R10: The target releases SDA after the falling SCL edge that ends an acknowledge clock, so a following controller-driven bit is not blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| addr_sel_i | input | 3 | Strap pins forming the low three address bits |
| sda_drive_low_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| cmd_ptr_o | output | 8 | Stored command pointer, register index to the bank |
| wr_data_o | output | 8 | Data byte for the register write |
| wr_pulse_o | output | 1 | One-cycle write strobe |
| rd_pulse_o | output | 1 | One-cycle read strobe; `rd_data_i` is captured in the same cycle |
| rd_data_i | input | 8 | Read data from the register bank |

## Verification
The bench targets pointer persistence. A Receive Byte must return the register that the last command selected. A design that reset its pointer at stop, or that only loaded it during Read Byte, would return the input port instead. A stream of Receive Bytes is checked against an input value that changes with every fetch, which catches a design that fetches once per transaction. Stops in mid-byte and just after the command are checked for stray writes. A wrong address and a changed strap value are checked for acknowledge behaviour, and a reset in mid-transaction is checked for a cleared pointer and a released SDA.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);
    localparam int PIN_W     = 3;
    localparam int HI_W      = 7 - PIN_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } xact_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] rx_byte,
                                      input logic [HI_W-1:0]   hi_bits,
                                      input logic [PIN_W-1:0]  pins);
        return rx_byte[BYTE_W-1:1] == {hi_bits, pins};
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        evt_o.scl      = scl_s;
        evt_o.sda      = sda_s;
        evt_o.scl_rise = scl_s & ~scl_q;
        evt_o.scl_fall = ~scl_s & scl_q;
        evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/smb_ptr_reg.sv
module smb_ptr_reg #(
    parameter int            W       = 8,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] ptr_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_o <= RST_VAL;
        end else if (load) begin
            ptr_o <= din;
        end
    end

endmodule

// File: rtl/smb_xact_fsm.sv
module smb_xact_fsm
    import smb_tgt_pkg::*;
#(
    parameter logic [HI_W-1:0] ADDR_HI = 4'b0011
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [PIN_W-1:0]  addr_pins,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_low,
    output logic              wr_pulse,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_pulse,
    output logic              ptr_load,
    output logic [BYTE_W-1:0] ptr_data
);

    localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] LAST_OUT = BIT_CNT_W'(BYTE_W - 1);

    xact_state_e           state_q;
    logic [BYTE_W-1:0]     shreg_q;
    logic [BIT_CNT_W-1:0]  cnt_q;
    logic                  rnw_q;
    logic                  mack_q;
    logic                  drive_q;
    logic                  wr_q;
    logic                  pl_q;
    logic [BYTE_W-1:0]     wdat_q;
    logic                  fetch;

    // A new byte is fetched at the end of the address ACK of a read, or at
    // the end of a controller ACK that asks for another byte.
    always_comb begin
        fetch = evt.scl_fall &&
                ((state_q == ST_ADDR_ACK && rnw_q) ||
                 (state_q == ST_RACK && mack_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
            rnw_q   <= 1'b0;
            mack_q  <= 1'b0;
            drive_q <= 1'b0;
            wr_q    <= 1'b0;
            pl_q    <= 1'b0;
            wdat_q  <= '0;
        end else begin
            wr_q <= 1'b0;
            pl_q <= 1'b0;
            if (evt.start) begin
                state_q <= ST_ADDR;
                cnt_q   <= '0;
                drive_q <= 1'b0;
            end else if (evt.stop) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
                drive_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (evt.scl_rise && cnt_q != FULL_CNT) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], evt.sda};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (evt.scl_fall && cnt_q == FULL_CNT) begin
                            cnt_q <= '0;
                            case (state_q)
                                ST_ADDR: begin
                                    if (addr_hit(shreg_q, ADDR_HI, addr_pins)) begin
                                        state_q <= ST_ADDR_ACK;
                                        rnw_q   <= shreg_q[0];
                                        drive_q <= 1'b1;
                                    end else begin
                                        state_q <= ST_IDLE;
                                    end
                                end
                                ST_CMD: begin
                                    state_q <= ST_CMD_ACK;
                                    drive_q <= 1'b1;
                                end
                                default: begin
                                    state_q <= ST_WDATA_ACK;
                                    drive_q <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            cnt_q <= '0;
                            if (rnw_q) begin
                                state_q <= ST_RDATA;
                                shreg_q <= rd_data;
                                drive_q <= ~rd_data[BYTE_W-1];
                            end else begin
                                state_q <= ST_CMD;
                                drive_q <= 1'b0;
                            end
                        end
                    end
                    ST_CMD_ACK: begin
                        if (evt.scl_fall) begin
                            state_q <= ST_WDATA;
                            drive_q <= 1'b0;
                            pl_q    <= 1'b1;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (evt.scl_fall) begin
                            state_q <= ST_WDATA;
                            drive_q <= 1'b0;
                            wr_q    <= 1'b1;
                            wdat_q  <= shreg_q;
                        end
                    end
                    ST_RDATA: begin
                        if (evt.scl_fall) begin
                            if (cnt_q == LAST_OUT) begin
                                state_q <= ST_RACK;
                                drive_q <= 1'b0;
                                cnt_q   <= '0;
                            end else begin
                                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                                drive_q <= ~shreg_q[BYTE_W-2];
                                cnt_q   <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise) begin
                            mack_q <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            if (mack_q) begin
                                state_q <= ST_RDATA;
                                shreg_q <= rd_data;
                                drive_q <= ~rd_data[BYTE_W-1];
                                cnt_q   <= '0;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        drive_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_low  = drive_q;
    assign wr_pulse = wr_q;
    assign wr_data  = wdat_q;
    assign rd_pulse = fetch;
    assign ptr_load = pl_q;
    assign ptr_data = shreg_q;

endmodule

// File: rtl/smb_cmdptr_target.sv
module smb_cmdptr_target
    import smb_tgt_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [HI_W-1:0]   ADDR_HI     = 4'b0011,
    parameter logic [BYTE_W-1:0] PTR_RST     = 8'h00
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            scl_i,
    input  logic                            sda_i,
    input  logic [smb_tgt_pkg::PIN_W-1:0]   addr_sel_i,
    output logic                            sda_drive_low_o,
    output logic [smb_tgt_pkg::BYTE_W-1:0]  cmd_ptr_o,
    output logic [smb_tgt_pkg::BYTE_W-1:0]  wr_data_o,
    output logic                            wr_pulse_o,
    output logic                            rd_pulse_o,
    input  logic [smb_tgt_pkg::BYTE_W-1:0]  rd_data_i
);

    bus_evt_t          bus_evt;
    logic              ptr_load;
    logic [BYTE_W-1:0] ptr_data;
    logic              scl_fall_w;
    logic              stop_w;

    smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (bus_evt)
    );

    smb_xact_fsm #(.ADDR_HI(ADDR_HI)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .evt       (bus_evt),
        .addr_pins (addr_sel_i),
        .rd_data   (rd_data_i),
        .sda_low   (sda_drive_low_o),
        .wr_pulse  (wr_pulse_o),
        .wr_data   (wr_data_o),
        .rd_pulse  (rd_pulse_o),
        .ptr_load  (ptr_load),
        .ptr_data  (ptr_data)
    );

    smb_ptr_reg #(.W(BYTE_W), .RST_VAL(PTR_RST)) ptr_i (
        .clk   (clk),
        .rst   (rst),
        .load  (ptr_load),
        .din   (ptr_data),
        .ptr_o (cmd_ptr_o)
    );

    assign scl_fall_w = bus_evt.scl_fall;
    assign stop_w     = bus_evt.stop;

endmodule

// File: rtl/smb_cmdptr_chk.sv
module smb_cmdptr_chk
    import smb_tgt_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PTR_RST = 8'h00
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_pulse,
    input logic              rd_pulse,
    input logic              sda_low,
    input logic              ptr_load,
    input logic              scl_fall,
    input logic              stop_det,
    input logic [BYTE_W-1:0] ptr
);

    AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst) wr_pulse |=> !wr_pulse); // R3
    AST_WR_AFTER_SCL_FALL: assert property (@(posedge clk) disable iff (rst) wr_pulse |-> $past(scl_fall)); // R3
    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(wr_pulse && rd_pulse)); // R6
    AST_PTR_MOVES_ON_LOAD: assert property (@(posedge clk) disable iff (rst) !$stable(ptr) |-> $past(ptr_load)); // R2
    AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (rst) stop_det |=> !sda_low); // R7
    AST_RESET_DEFAULTS: assert property (@(posedge clk) $past(rst) |-> (!sda_low && ptr == PTR_RST)); // R8

endmodule

bind smb_cmdptr_target smb_cmdptr_chk #(.PTR_RST(PTR_RST)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_pulse (wr_pulse_o),
    .rd_pulse (rd_pulse_o),
    .sda_low  (sda_drive_low_o),
    .ptr_load (ptr_load),
    .scl_fall (scl_fall_w),
    .stop_det (stop_w),
    .ptr      (cmd_ptr_o)
);

// File: tb/smb_cmdptr_target_tb_top.sv
`timescale 1ns/1ps
module smb_cmdptr_target_tb_top;

    localparam int Q = 10;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] wdat;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'h01, 8'hA5, 8'hA5},
        '{8'h02, 8'h3C, 8'h3C},
        '{8'h03, 8'h0F, 8'h0F},
        '{8'h01, 8'h5A, 8'h5A}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] pins = 3'b101;
    logic       drv;
    logic [7:0] ptr, wdat, rdat;
    logic       wr_p, rd_p;
    logic       sda_line;

    logic [7:0] out_r, pol_r, cfg_r;
    int         rd_cnt = 0;
    int         wr_cnt = 0;
    int         drv_cycles = 0;
    int         total = 0;
    int         bad = 0;
    logic       late_drv;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~drv;

    smb_cmdptr_target dut_i (
        .clk             (clk),
        .rst             (rst),
        .scl_i           (scl_m),
        .sda_i           (sda_line),
        .addr_sel_i      (pins),
        .sda_drive_low_o (drv),
        .cmd_ptr_o       (ptr),
        .wr_data_o       (wdat),
        .wr_pulse_o      (wr_p),
        .rd_pulse_o      (rd_p),
        .rd_data_i       (rdat)
    );

    // Bench register bank: 0 input port (changes after each fetch), 1..3 storage
    always_comb begin
        case (ptr[1:0])
            2'd0:    rdat = 8'h30 + 8'(rd_cnt);
            2'd1:    rdat = out_r;
            2'd2:    rdat = pol_r;
            default: rdat = cfg_r;
        endcase
    end

    always @(posedge clk) begin
        if (rst) begin
            out_r <= 8'h00;
            pol_r <= 8'h00;
            cfg_r <= 8'hFF;
        end else if (wr_p) begin
            wr_cnt <= wr_cnt + 1;
            case (ptr[1:0])
                2'd1: out_r <= wdat;
                2'd2: pol_r <= wdat;
                2'd3: cfg_r <= wdat;
                default: ;
            endcase
        end
        if (rd_p) rd_cnt <= rd_cnt + 1;
    end

    always @(negedge clk) if (drv) drv_cycles <= drv_cycles + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
        late_drv = drv;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(~give_ack);
    endtask

    function automatic logic [7:0] addr_byte(input logic rnw);
        return {4'b0011, pins, rnw};
    endfunction

    task automatic rd_reg(input logic [7:0] cmd, output logic [7:0] d);
        logic a;
        bus_start();
        send_byte(addr_byte(1'b0), a);
        send_byte(cmd, a);
        bus_start();
        send_byte(addr_byte(1'b1), a);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        logic       a0, a1, a2;
        logic [7:0] d;
        int         w0, r0, c0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        wq();
        // R8: reset state
        chk("R8 sda released after reset", drv, 1'b0);
        chk("R8 pointer default", ptr, 8'h00);
        chk("R8 no write strobe", wr_p, 1'b0);

        // Table: Write Byte then Read Byte for each vector
        foreach (VECS[k]) begin
            w0 = wr_cnt;
            bus_start();
            send_byte(addr_byte(1'b0), a0);
            chk("R10 released after address ACK", late_drv, 1'b0);
            send_byte(VECS[k].cmd, a1);
            chk("R10 released after command ACK", late_drv, 1'b0);
            send_byte(VECS[k].wdat, a2);
            bus_stop();
            chk("R1 address acked", a0, 1'b1);
            chk("R3 data acked", a1 & a2, 1'b1);
            chk("R3 single write per byte", wr_cnt - w0, 1);
            chk("R2 pointer holds command", ptr, VECS[k].cmd);
            rd_reg(VECS[k].cmd, d);
            chk("R4 Read Byte returns register (R9 repeated start)", d, VECS[k].exp);
        end

        // R1: wrong address ignored
        c0 = drv_cycles;
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h38, a0);
        send_byte(8'h02, a1);
        send_byte(8'h77, a2);
        bus_stop();
        chk("R1 wrong address not acked", a0, 1'b0);
        chk("R1 no SDA drive on mismatch", drv_cycles - c0, 0);
        chk("R1 no write on mismatch", wr_cnt - w0, 0);
        chk("R2 pointer untouched on mismatch", ptr, 8'h01);

        // R1: new strap value moves the address
        pins = 3'b010;
        rd_reg(8'h02, d);
        chk("R1 strap change still matched", d, 8'h3C);

        // R5: Receive Byte uses stored pointer (2), twice
        for (int n = 0; n < 2; n++) begin
            bus_start();
            send_byte(addr_byte(1'b1), a0);
            recv_byte(1'b0, d);
            bus_stop();
            chk("R5 Receive Byte uses stored pointer", d, 8'h3C);
        end

        // R7: command then stop -> pointer set, no write
        w0 = wr_cnt;
        bus_start();
        send_byte(addr_byte(1'b0), a0);
        send_byte(8'h00, a1);
        bus_stop();
        chk("R7 stop after command writes nothing", wr_cnt - w0, 0);
        chk("R2 pointer set by command-only write", ptr, 8'h00);

        // R6: streamed Receive Byte re-samples input port
        r0 = rd_cnt;
        bus_start();
        send_byte(addr_byte(1'b1), a0);
        recv_byte(1'b1, d);
        chk("R6 stream byte 0", d, 8'h30 + 8'(r0));
        recv_byte(1'b1, d);
        chk("R6 stream byte 1 fresh", d, 8'h30 + 8'(r0 + 1));
        recv_byte(1'b0, d);
        chk("R6 stream byte 2 fresh", d, 8'h30 + 8'(r0 + 2));
        bus_stop();
        chk("R6 one fetch per byte, none after NACK", rd_cnt - r0, 3);

        // R7: stop in the middle of a data byte
        w0 = wr_cnt;
        bus_start();
        send_byte(addr_byte(1'b0), a0);
        send_byte(8'h02, a1);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        scl_m = 1'b0; wq();
        bus_stop();
        chk("R7 partial byte discarded", wr_cnt - w0, 0);
        chk("R7 sda released after stop", drv, 1'b0);
        rd_reg(8'h02, d);
        chk("R7 register unchanged", d, 8'h3C);

        // R8: reset in mid-transaction
        bus_start();
        send_byte(addr_byte(1'b0), a0);
        send_byte(8'h03, a1);
        chk("R2 pointer before reset", ptr, 8'h03);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R8 pointer cleared mid-transaction", ptr, 8'h00);
        chk("R8 sda released mid-transaction", drv, 1'b0);
        bus_stop();
        r0 = rd_cnt;
        bus_start();
        send_byte(addr_byte(1'b1), a0);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R8 Receive Byte after reset reads input port", d, 8'h30 + 8'(r0));

        finish_run();
    end

endmodule